// File: doc/BRIEF.md
# Spiral-Order SAD Block Matcher

This block looks for the position in a reference frame that best matches one square block of the current frame. It is used for motion estimation and for matching a block against a stored reference. The block reads current-block pixels and reference pixels from two buffers outside itself, through address outputs and combinational read-data inputs. Each candidate displacement (dx, dy) inside a square search window is scored by the sum of absolute differences (SAD) over every pixel of the block. The displacement with the lowest score is reported.

Candidates are not scanned row by row. The walk begins at zero displacement and then circles outward one ring at a time. Within each ring it starts at the upper-left corner, then runs right along the top edge, down the right edge, left along the bottom edge and up the left edge. On a tie the result therefore favours the smallest displacement. A candidate whose window would reach past the edge of the reference buffer costs one cycle and is passed over. The search time depends only on where the block sits, never on the pixel data.

The block size, pixel width, search range and reference buffer dimensions are parameters. The defaults are an 8x8 block, 8-bit pixels, a range of plus or minus 4 and a 32x32 reference buffer.

Top module: `sad_block_matcher`

## Requirements
- R1: While rst_n is low and after it is released, busy, done, best_dx, best_dy and best_sad are all zero.
- R2: On completion, best_sad equals the minimum over all in-bounds candidates of the sum over the BLK*BLK pixels of |cur(row,col) - ref(blk_y+dy+row, blk_x+dx+col)|. The current buffer is addressed row*BLK+col and the reference buffer y*REF_W+x, both read combinationally. best_dx and best_dy are that candidate's displacement in two's complement, with positive meaning right and down.
- R3: The SAD path is wide enough for the worst case. With every current pixel at 255 and every reference pixel at 0, best_sad is 16320 (BLK*BLK*255) without wrapping.
- R4: Candidates are taken in spiral order. First comes (0,0). Then, for r = 1 to RANGE, the ring starts at (-r,-r), goes right to (r,-r), down to (r,r), left to (-r,r) and up to (-r,-r+1). Among equal SADs the candidate met first in this order is reported.
- R5: A candidate is in bounds only if blk_x+dx >= 0, blk_x+dx+BLK <= REF_W, blk_y+dy >= 0 and blk_y+dy+BLK <= REF_H. Other candidates are skipped and never reported, and the walk goes on to the next candidate. The block itself must lie inside the buffer.
- R6: done is high for exactly one cycle and carries the results. busy is high from the cycle after start is sampled until done rises, and it is low while done is high.
- R7: Latency is fixed. With start sampled at clock edge E0, done is first seen after edge E0 + (BLK*BLK+2)*V + S, where V is the number of in-bounds candidates and S the number skipped.
- R8: A start pulse that arrives while busy is high is ignored. The running search keeps its block position, its result and its latency.
- R9: best_dx, best_dy and best_sad change only together with done, and keep their values while the block is idle, even if blk_x and blk_y change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search; sampled only when idle |
| blk_x | input | $clog2(REF_W) | Column of the block's upper-left pixel in the reference buffer |
| blk_y | input | $clog2(REF_H) | Row of the block's upper-left pixel in the reference buffer |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_dx | output | $clog2(RANGE+1)+1 | Signed horizontal displacement of the best match |
| best_dy | output | $clog2(RANGE+1)+1 | Signed vertical displacement of the best match |
| best_sad | output | $clog2(BLK*BLK*(2**PIX_W-1))+1 | SAD of the best match |
| cur_addr | output | $clog2(BLK*BLK) | Current-block buffer address, row*BLK+col |
| cur_pix | input | PIX_W | Current-block pixel at cur_addr, same cycle |
| ref_addr | output | $clog2(REF_W*REF_H) | Reference buffer address, y*REF_W+x |
| ref_pix | input | PIX_W | Reference pixel at ref_addr, same cycle |

## Verification
The tie case uses a reference pattern that repeats every two pixels, so every odd/odd displacement matches exactly. A design that kept the later of two equal scores, or walked a ring in another direction, would report a different vector than (-1,-1). Blocks placed against the top-left and bottom-right corners of the buffer force most candidates out of bounds. A design with a wrong bounds test would read wrapped addresses, report a vector outside the buffer, or miss the fixed latency of 1706 cycles. An all-255 block over an all-zero reference sums to the largest possible SAD, which a narrow accumulator would wrap. A second start pulse in mid-search checks that the latched position does not change, which would otherwise corrupt both the result and the cycle count.

// File: rtl/sad_pkg.sv
// Shared types and width helpers for the SAD block matcher.
// Assumes pixel widths below 31 bits so width arithmetic stays in int.
package sad_pkg;

    // Controller phases: waiting, judging a candidate, summing, comparing
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ACC   = 2'd2,
        ST_CMP   = 2'd3
    } sad_state_t;

    // Accumulator width that holds npix maximal differences plus one spare bit
    function automatic int sad_acc_width(input int npix, input int pix_w);
        return $clog2(npix * ((1 << pix_w) - 1)) + 1;
    endfunction

endpackage

// File: rtl/sad_spiral_gen.sv
// Walks candidate displacements outward from (0,0) one ring at a time.
// Each ring r starts at (-r,-r), then runs right, down, left and up, ending at (-r,-r+1).
// Assumes RANGE >= 1. 'last' flags the final point of the outermost ring.
module sad_spiral_gen #(
    parameter int RANGE = 4,
    parameter int RW    = $clog2(RANGE + 1),
    parameter int DW    = RW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 step,
    output logic signed [DW-1:0] dx,
    output logic signed [DW-1:0] dy,
    output logic                 last
);

    localparam logic signed [DW-1:0] ONE = DW'(1);

    logic [RW-1:0]        ring_q;
    logic [RW-1:0]        ring_n;
    logic signed [DW-1:0] rs;
    logic signed [DW-1:0] nx;
    logic signed [DW-1:0] ny;

    assign rs = $signed({1'b0, ring_q});

    // Next point along the current ring edge, or the corner of the next ring
    always_comb begin
        nx     = dx;
        ny     = dy;
        ring_n = ring_q;
        if (ring_q == '0) begin
            nx     = -ONE;
            ny     = -ONE;
            ring_n = RW'(1);
        end else if (dy == -rs && dx < rs) begin
            nx = dx + ONE;
        end else if (dx == rs && dy < rs) begin
            ny = dy + ONE;
        end else if (dy == rs && dx > -rs) begin
            nx = dx - ONE;
        end else if (dx == -rs && dy > -rs + ONE) begin
            ny = dy - ONE;
        end else begin
            ring_n = ring_q + RW'(1);
            nx     = -rs - ONE;
            ny     = -rs - ONE;
        end
    end

    // Position register: back to the origin on init, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            dx     <= '0;
            dy     <= '0;
            ring_q <= '0;
        end else if (step) begin
            dx     <= nx;
            dy     <= ny;
            ring_q <= ring_n;
        end
    end

    assign last = (ring_q == RW'(RANGE)) && (dx == -rs) && (dy == -rs + ONE);

endmodule

// File: rtl/sad_window.sv
// Bounds test and address generation for one candidate window.
// Assumes both buffers are read combinationally, row-major (cur: row*BLK+col, ref: y*REF_W+x).
module sad_window #(
    parameter int BLK   = 8,
    parameter int REF_W = 32,
    parameter int REF_H = 32,
    parameter int DW    = 4,
    parameter int XW    = $clog2(REF_W),
    parameter int YW    = $clog2(REF_H),
    parameter int IW    = $clog2(BLK),
    parameter int CAW   = $clog2(BLK * BLK),
    parameter int RAW   = $clog2(REF_W * REF_H)
) (
    input  logic [XW-1:0]        bx,
    input  logic [YW-1:0]        by,
    input  logic signed [DW-1:0] dx,
    input  logic signed [DW-1:0] dy,
    input  logic [IW-1:0]        row,
    input  logic [IW-1:0]        col,
    output logic                 ok,
    output logic [CAW-1:0]       cur_addr,
    output logic [RAW-1:0]       ref_addr
);

    int cx;
    int cy;

    // Candidate origin in frame coordinates, then bounds and addresses
    always_comb begin
        cx       = int'(bx) + int'(dx);
        cy       = int'(by) + int'(dy);
        ok       = (cx >= 0) && (cx + BLK <= REF_W) && (cy >= 0) && (cy + BLK <= REF_H);
        ref_addr = RAW'((cy + int'(row)) * REF_W + cx + int'(col));
        cur_addr = CAW'(int'(row) * BLK + int'(col));
    end

endmodule

// File: rtl/sad_accum.sv
// Adds one absolute pixel difference per enabled cycle, walking row and column counters.
// Assumes BLK >= 2. 'last_pix' marks the final pixel of the block.
module sad_accum #(
    parameter int BLK   = 8,
    parameter int PIX_W = 8,
    parameter int SW    = 15,
    parameter int IW    = $clog2(BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [IW-1:0]    row,
    output logic [IW-1:0]    col,
    output logic [SW-1:0]    acc,
    output logic             last_pix
);

    logic [PIX_W-1:0] diff;

    // Absolute difference without a sign bit
    always_comb begin
        diff = (a >= b) ? (a - b) : (b - a);
    end

    assign last_pix = (row == IW'(BLK - 1)) && (col == IW'(BLK - 1));

    // Sum register and raster counters over the block
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            row <= '0;
            col <= '0;
        end else if (en) begin
            acc <= acc + SW'(diff);
            if (col == IW'(BLK - 1)) begin
                col <= '0;
                row <= last_pix ? '0 : row + IW'(1);
            end else begin
                col <= col + IW'(1);
            end
        end
    end

endmodule

// File: rtl/sad_block_matcher.sv
// Full-search block matcher with a centre-out spiral visiting order.
// Per in-bounds candidate: one judge cycle, BLK*BLK summing cycles, one compare cycle.
// An out-of-bounds candidate costs one judge cycle. Strict-less compare keeps the earliest tie.
// Assumes the block lies inside the reference buffer, so (0,0) is always in bounds.
module sad_block_matcher #(
    parameter  int BLK   = 8,
    parameter  int PIX_W = 8,
    parameter  int RANGE = 4,
    parameter  int REF_W = 32,
    parameter  int REF_H = 32,
    localparam int XW    = $clog2(REF_W),
    localparam int YW    = $clog2(REF_H),
    localparam int RW    = $clog2(RANGE + 1),
    localparam int DW    = RW + 1,
    localparam int IW    = $clog2(BLK),
    localparam int CAW   = $clog2(BLK * BLK),
    localparam int RAW   = $clog2(REF_W * REF_H),
    localparam int SW    = sad_pkg::sad_acc_width(BLK * BLK, PIX_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [XW-1:0]        blk_x,
    input  logic [YW-1:0]        blk_y,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] best_dx,
    output logic signed [DW-1:0] best_dy,
    output logic [SW-1:0]        best_sad,
    output logic [CAW-1:0]       cur_addr,
    input  logic [PIX_W-1:0]     cur_pix,
    output logic [RAW-1:0]       ref_addr,
    input  logic [PIX_W-1:0]     ref_pix
);

    import sad_pkg::*;

    sad_state_t           state_q;
    logic [XW-1:0]        bx_q;
    logic [YW-1:0]        by_q;
    logic [SW-1:0]        run_sad;
    logic signed [DW-1:0] run_dx;
    logic signed [DW-1:0] run_dy;

    logic signed [DW-1:0] sp_dx;
    logic signed [DW-1:0] sp_dy;
    logic                 sp_last;
    logic                 sp_init;
    logic                 sp_step;
    logic                 cand_ok;
    logic [IW-1:0]        row;
    logic [IW-1:0]        col;
    logic [SW-1:0]        acc;
    logic                 last_pix;
    logic                 acc_clr;
    logic                 acc_en;
    logic                 better;

    // Handshakes between the controller and the walker / summer
    always_comb begin
        sp_init = (state_q == ST_IDLE) && start;
        sp_step = ((state_q == ST_CHECK) && !cand_ok && !sp_last) ||
                  ((state_q == ST_CMP) && !sp_last);
        acc_clr = (state_q == ST_CHECK) && cand_ok;
        acc_en  = (state_q == ST_ACC);
        better  = (acc < run_sad);
    end

    assign busy = (state_q != ST_IDLE);

    sad_spiral_gen #(
        .RANGE (RANGE),
        .RW    (RW),
        .DW    (DW)
    ) spiral_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (sp_init),
        .step  (sp_step),
        .dx    (sp_dx),
        .dy    (sp_dy),
        .last  (sp_last)
    );

    sad_window #(
        .BLK   (BLK),
        .REF_W (REF_W),
        .REF_H (REF_H),
        .DW    (DW),
        .XW    (XW),
        .YW    (YW),
        .IW    (IW),
        .CAW   (CAW),
        .RAW   (RAW)
    ) window_i (
        .bx       (bx_q),
        .by       (by_q),
        .dx       (sp_dx),
        .dy       (sp_dy),
        .row      (row),
        .col      (col),
        .ok       (cand_ok),
        .cur_addr (cur_addr),
        .ref_addr (ref_addr)
    );

    sad_accum #(
        .BLK   (BLK),
        .PIX_W (PIX_W),
        .SW    (SW),
        .IW    (IW)
    ) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .en       (acc_en),
        .a        (cur_pix),
        .b        (ref_pix),
        .row      (row),
        .col      (col),
        .acc      (acc),
        .last_pix (last_pix)
    );

    // Controller: phase sequencing, running minimum and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bx_q     <= '0;
            by_q     <= '0;
            run_sad  <= '1;
            run_dx   <= '0;
            run_dy   <= '0;
            done     <= 1'b0;
            best_dx  <= '0;
            best_dy  <= '0;
            best_sad <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        bx_q    <= blk_x;
                        by_q    <= blk_y;
                        run_sad <= '1;
                        run_dx  <= '0;
                        run_dy  <= '0;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cand_ok) begin
                        state_q <= ST_ACC;
                    end else if (sp_last) begin
                        done     <= 1'b1;
                        best_sad <= run_sad;
                        best_dx  <= run_dx;
                        best_dy  <= run_dy;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_ACC: begin
                    if (last_pix) begin
                        state_q <= ST_CMP;
                    end
                end
                ST_CMP: begin
                    if (better) begin
                        run_sad <= acc;
                        run_dx  <= sp_dx;
                        run_dy  <= sp_dy;
                    end
                    if (sp_last) begin
                        done     <= 1'b1;
                        best_sad <= better ? acc : run_sad;
                        best_dx  <= better ? sp_dx : run_dx;
                        best_dy  <= better ? sp_dy : run_dy;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_CHECK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sad_block_matcher_chk.sv
// Temporal checks on the matcher's ports and latched block position.
// Bound into every instance of sad_block_matcher at the end of this file.
module sad_block_matcher_chk #(
    parameter  int BLK   = 8,
    parameter  int PIX_W = 8,
    parameter  int RANGE = 4,
    parameter  int REF_W = 32,
    parameter  int REF_H = 32,
    localparam int XW    = $clog2(REF_W),
    localparam int YW    = $clog2(REF_H),
    localparam int DW    = $clog2(RANGE + 1) + 1,
    localparam int SW    = sad_pkg::sad_acc_width(BLK * BLK, PIX_W)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic signed [DW-1:0] best_dx,
    input logic signed [DW-1:0] best_dy,
    input logic [SW-1:0]        best_sad,
    input logic [XW-1:0]        bx_q,
    input logic [YW-1:0]        by_q
);

    localparam int MAX_SAD = BLK * BLK * ((1 << PIX_W) - 1);

    // R6: completion lasts exactly one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R6: busy is low whenever done is shown
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

    // R8: a search only begins from a sampled start
    p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));

    // R3: reported score never exceeds the largest possible block SAD
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(best_sad) <= MAX_SAD));

    // R5: reported vector lies inside the search range and the buffer
    p_vec_in_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(best_dx) >= -RANGE && int'(best_dx) <= RANGE &&
                  int'(best_dy) >= -RANGE && int'(best_dy) <= RANGE &&
                  int'(bx_q) + int'(best_dx) >= 0 && int'(bx_q) + int'(best_dx) + BLK <= REF_W &&
                  int'(by_q) + int'(best_dy) >= 0 && int'(by_q) + int'(best_dy) + BLK <= REF_H));

    // R9: results move only together with done
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_sad) && $stable(best_dx) && $stable(best_dy)));

endmodule

bind sad_block_matcher sad_block_matcher_chk #(
    .BLK   (BLK),
    .PIX_W (PIX_W),
    .RANGE (RANGE),
    .REF_W (REF_W),
    .REF_H (REF_H)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .best_dx  (best_dx),
    .best_dy  (best_dy),
    .best_sad (best_sad),
    .bx_q     (bx_q),
    .by_q     (by_q)
);

// File: tb/sad_block_matcher_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the spiral SAD block matcher: one task per scenario.
module sad_block_matcher_tb_top;

    localparam int BLK   = 8;
    localparam int PIX_W = 8;
    localparam int RANGE = 4;
    localparam int REF_W = 32;
    localparam int REF_H = 32;
    localparam int NCAND = (2 * RANGE + 1) * (2 * RANGE + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [4:0]        blk_x = '0;
    logic [4:0]        blk_y = '0;
    logic              busy;
    logic              done;
    logic signed [3:0] best_dx;
    logic signed [3:0] best_dy;
    logic [14:0]       best_sad;
    logic [5:0]        cur_addr;
    logic [7:0]        cur_pix;
    logic [9:0]        ref_addr;
    logic [7:0]        ref_pix;

    logic [7:0] cur_mem [BLK*BLK];
    logic [7:0] ref_mem [REF_W*REF_H];
    int ord_x [NCAND];
    int ord_y [NCAND];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    assign cur_pix = cur_mem[cur_addr];
    assign ref_pix = ref_mem[ref_addr];

    always #4 clk = ~clk;

    sad_block_matcher #(
        .BLK(BLK), .PIX_W(PIX_W), .RANGE(RANGE), .REF_W(REF_W), .REF_H(REF_H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_x(blk_x), .blk_y(blk_y),
        .busy(busy), .done(done), .best_dx(best_dx), .best_dy(best_dy), .best_sad(best_sad),
        .cur_addr(cur_addr), .cur_pix(cur_pix), .ref_addr(ref_addr), .ref_pix(ref_pix)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    // Spiral order written out from R4: ring corners and edge directions
    task automatic build_order();
        int n = 0;
        ord_x[n] = 0; ord_y[n] = 0; n++;
        for (int r = 1; r <= RANGE; r++) begin
            for (int x = -r; x <= r; x++) begin ord_x[n] = x; ord_y[n] = -r; n++; end
            for (int y = -r + 1; y <= r; y++) begin ord_x[n] = r; ord_y[n] = y; n++; end
            for (int x = r - 1; x >= -r; x--) begin ord_x[n] = x; ord_y[n] = r; n++; end
            for (int y = r - 1; y >= -r + 1; y--) begin ord_x[n] = -r; ord_y[n] = y; n++; end
        end
    endtask

    function automatic int sad_at(input int bx, input int by);
        int s = 0;
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++) begin
                int a = int'(cur_mem[r*BLK+c]);
                int b = int'(ref_mem[(by+r)*REF_W + bx + c]);
                s += (a > b) ? a - b : b - a;
            end
        return s;
    endfunction

    // Expected result and latency from R2, R4, R5 and R7
    task automatic model(input int bx, input int by, output int edx, output int edy,
                         output int esad, output int elat);
        esad = 32'h7fff_ffff; edx = 0; edy = 0; elat = 0;
        for (int i = 0; i < NCAND; i++) begin
            int cx = bx + ord_x[i];
            int cy = by + ord_y[i];
            if (cx >= 0 && cx + BLK <= REF_W && cy >= 0 && cy + BLK <= REF_H) begin
                int s = sad_at(cx, cy);
                elat += BLK * BLK + 2;
                if (s < esad) begin esad = s; edx = ord_x[i]; edy = ord_y[i]; end
            end else begin
                elat += 1;
            end
        end
    endtask

    task automatic fill_ref_random();
        for (int i = 0; i < REF_W*REF_H; i++) ref_mem[i] = 8'(rnd8());
    endtask

    task automatic fill_cur_random();
        for (int i = 0; i < BLK*BLK; i++) cur_mem[i] = 8'(rnd8());
    endtask

    task automatic copy_cur_from_ref(input int x, input int y);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++) cur_mem[r*BLK+c] = ref_mem[(y+r)*REF_W + x + c];
    endtask

    // Runs one search; checks busy/done shape (R6); optional extra start mid-search
    task automatic run_search(input int bx, input int by, input int inj_at,
                              output int lat, output int rdx, output int rdy, output int rsad);
        int busy_bad = 0;
        @(negedge clk);
        blk_x = 5'(bx); blk_y = 5'(by); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20000) begin
            if (!busy) busy_bad++;
            if (lat == inj_at) begin
                start = 1'b1; blk_x = 5'(0); blk_y = 5'(0);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk_eq("R6", "busy high throughout search", busy_bad, 0);
        chk_eq("R6", "busy low with done", int'(busy), 0);
        rdx = int'(best_dx); rdy = int'(best_dy); rsad = int'(best_sad);
        @(negedge clk);
        chk_eq("R6", "done lasts one cycle", int'(done), 0);
    endtask

    task automatic compare_model(input string req, input int bx, input int by, input int inj_at);
        int lat, dx, dy, s, edx, edy, es, el;
        model(bx, by, edx, edy, es, el);
        run_search(bx, by, inj_at, lat, dx, dy, s);
        chk_eq(req, "best_sad", s, es);
        chk_eq(req, "best_dx", dx, edx);
        chk_eq(req, "best_dy", dy, edy);
        chk_eq("R7", "latency", lat, el);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R1", "busy in reset", int'(busy), 0);
        chk_eq("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "best_sad after reset", int'(best_sad), 0);
        chk_eq("R1", "best_dx after reset", int'(best_dx), 0);
        chk_eq("R1", "best_dy after reset", int'(best_dy), 0);
        chk_eq("R1", "busy after reset", int'(busy), 0);
    endtask

    // R2: exact copy planted at (+2,-3) in random data
    task automatic t_planted();
        int lat, dx, dy, s;
        fill_ref_random();
        copy_cur_from_ref(14, 7);
        run_search(12, 10, -1, lat, dx, dy, s);
        chk_eq("R2", "planted dx", dx, 2);
        chk_eq("R2", "planted dy", dy, -3);
        chk_eq("R2", "planted sad", s, 0);
        chk_eq("R7", "full-window latency", lat, (BLK*BLK + 2) * NCAND);
    endtask

    // R2: unrelated random block, minimum taken from the model
    task automatic t_random();
        fill_ref_random();
        fill_cur_random();
        compare_model("R2", 9, 13, -1);
    endtask

    // R3: largest possible SAD at every candidate
    task automatic t_max_sad();
        int lat, dx, dy, s;
        for (int i = 0; i < REF_W*REF_H; i++) ref_mem[i] = 8'd0;
        for (int i = 0; i < BLK*BLK; i++) cur_mem[i] = 8'd255;
        run_search(10, 10, -1, lat, dx, dy, s);
        chk_eq("R3", "max sad", s, 16320);
        chk_eq("R3", "max sad dx (first in spiral)", dx, 0);
        chk_eq("R3", "max sad dy (first in spiral)", dy, 0);
    endtask

    // R4: period-2 pattern, every odd/odd offset scores zero; (-1,-1) comes first
    task automatic t_tie();
        int lat, dx, dy, s;
        for (int y = 0; y < REF_H; y++)
            for (int x = 0; x < REF_W; x++)
                ref_mem[y*REF_W + x] = 8'(((x % 2) * 2 + (y % 2)) * 50 + 20);
        copy_cur_from_ref(13, 13);
        run_search(12, 12, -1, lat, dx, dy, s);
        chk_eq("R4", "tie dx", dx, -1);
        chk_eq("R4", "tie dy", dy, -1);
        chk_eq("R4", "tie sad", s, 0);
    endtask

    // R5: block in the top-left and bottom-right corners
    task automatic t_corners();
        int lat, dx, dy, s;
        fill_ref_random();
        copy_cur_from_ref(3, 2);
        run_search(0, 0, -1, lat, dx, dy, s);
        chk_eq("R5", "top-left dx", dx, 3);
        chk_eq("R5", "top-left dy", dy, 2);
        chk_eq("R7", "top-left latency", lat, 25 * (BLK*BLK + 2) + 56);
        copy_cur_from_ref(22, 21);
        run_search(24, 24, -1, lat, dx, dy, s);
        chk_eq("R5", "bottom-right dx", dx, -2);
        chk_eq("R5", "bottom-right dy", dy, -3);
        chk_eq("R5", "bottom-right sad", s, 0);
        fill_cur_random();
        compare_model("R5", 1, 30 - BLK, -1);
    endtask

    // R8: a second start mid-search must not move the block or reset the count
    task automatic t_start_busy();
        fill_ref_random();
        copy_cur_from_ref(11, 12);
        compare_model("R8", 12, 10, 100);
    endtask

    // R9: results hold while idle even if the position inputs move
    task automatic t_hold();
        int dx0 = int'(best_dx);
        int dy0 = int'(best_dy);
        int s0  = int'(best_sad);
        blk_x = 5'd3; blk_y = 5'd17;
        repeat (30) @(negedge clk);
        chk_eq("R9", "idle best_sad", int'(best_sad), s0);
        chk_eq("R9", "idle best_dx", int'(best_dx), dx0);
        chk_eq("R9", "idle best_dy", int'(best_dy), dy0);
        chk_eq("R9", "idle busy", int'(busy), 0);
    endtask

    initial begin
        build_order();
        for (int i = 0; i < BLK*BLK; i++) cur_mem[i] = 8'd0;
        for (int i = 0; i < REF_W*REF_H; i++) ref_mem[i] = 8'd0;
        t_reset();
        t_planted();
        t_random();
        t_max_sad();
        t_tie();
        t_corners();
        t_start_busy();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule